// File: doc/BRIEF.md
# Wraparound Instruction Extractor

The extractor pulls variable-length instruction words out of a circular instruction line buffer and hands them, one per cycle, to a per-thread instruction queue. It holds a read pointer, in 32-bit dword units, into the buffer. From that pointer and the valid-line information published by the line buffer, it works out how many contiguous valid dwords lie ahead. It finds each instruction's length from a small encoding field and advances the pointer by that length.

The buffer holds `DEPTH` lines of `LINE_DW` dwords each, so it is `BUF_DW` dwords long. The pointer may rest on any dword `0..BUF_DW-1`, or exactly at `BUF_DW`, which is the physical end. An instruction that starts on the last dword is stitched together from that dword and dword 0. The pointer then lands just past the tail piece at the start of the buffer. When the line buffer reports a completed fill while the pointer sits at the end, the pointer wraps to 0. A load input repositions the pointer, for example after a branch.

Only length decoding is done here. Full opcode decoding belongs to the consumer of the queue.

Top module: `insn_extractor`

## Requirements
- R1: Out of reset, `rd_ptr_o` is 0 and `push_valid_o` is 0 when no line is valid.
- R2: The available count is the number of dwords from `rd_ptr_o` to the end of the newest valid line. The end of the newest line is `(newest_line_i+1)*LINE_DW`. If that end lies below the pointer, `valid_lines_i*LINE_DW` is added, and a negative result counts as 0. A push needs at least 2 available dwords (8 bytes), even for a 4-byte instruction.
- R3: No push occurs when `valid_lines_i` is 0, when `rd_ptr_o` equals `BUF_DW`, or when the newest line ends exactly at the pointer.
- R4: `push_valid_o` is asserted only while `q_count_i < IQ_MAX`. At most one instruction is pushed per cycle.
- R5: An instruction is 8 bytes when bits 31:30 of its first dword are `2'b11`, and 4 bytes otherwise; `push_long_o` reports which. `push_insn_o` holds the first dword in bits 31:0. For an 8-byte instruction, bits 63:32 hold the next dword; for a 4-byte instruction they are zero.
- R6: After a push that does not split, `rd_ptr_o` advances by 1 dword (4-byte instruction) or 2 dwords (8-byte instruction).
- R7: When the pointer is at `BUF_DW-1`, the read splits. The low dword comes from address `BUF_DW-1` and the high dword from address 0. After the push, `rd_ptr_o` becomes 1 for an 8-byte instruction and 0 for a 4-byte instruction.
- R8: `fill_done_i` wraps `rd_ptr_o` from `BUF_DW` to 0. At any other pointer value it has no effect.
- R9: `load_i` sets `rd_ptr_o` to `load_ptr_i` on the next edge. It takes priority over advance and wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Reposition the read pointer |
| load_ptr_i | input | PTR_W | New pointer value, in dwords |
| fill_done_i | input | 1 | A line fill completed this cycle |
| valid_lines_i | input | VL_W | Number of valid lines in the buffer |
| newest_line_i | input | LN_W | Index of the most recently filled line |
| rd_lo_addr_o | output | AW | Dword address of the instruction's first dword |
| rd_lo_data_i | input | 32 | Buffer data at `rd_lo_addr_o` |
| rd_hi_addr_o | output | AW | Dword address of the instruction's second dword |
| rd_hi_data_i | input | 32 | Buffer data at `rd_hi_addr_o` |
| q_count_i | input | QC_W | Current instruction queue occupancy |
| push_valid_o | output | 1 | Push an instruction into the queue this cycle |
| push_insn_o | output | 64 | Instruction word being pushed |
| push_long_o | output | 1 | The pushed instruction is 8 bytes |
| rd_ptr_o | output | PTR_W | Current read pointer, in dwords |

## Verification
The assertions take for granted that the buffer read port returns data combinationally for the addresses presented. They also assume that `load_ptr_i` never exceeds `BUF_DW`. The valid-line information is assumed to be consistent with the pointer: whenever the newest line ends below the pointer, the whole buffer is valid, so the wrapped count is exact. The stimulus loads only in-range pointers and uses a full buffer in every wrapped scenario. Where a partial buffer is used, the pointer stays inside the valid region. The queue occupancy that the bench drives follows its own model of pushes and pops, so it never goes above `IQ_MAX`.

// File: rtl/xtr_pkg.sv
package xtr_pkg;
  // long form when the two top bits of the first dword are both set
  function automatic logic is_long(input logic [31:0] dw);
    return dw[31:30] == 2'b11;
  endfunction
endpackage

// File: rtl/xtr_avail.sv
module xtr_avail #(
  parameter int LINE_DW = 4,
  parameter int DEPTH   = 4,
  parameter int PTR_W   = 5,
  parameter int VL_W    = 3,
  parameter int LN_W    = 2
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [VL_W-1:0]  valid_lines_i,
  input  logic [LN_W-1:0]  newest_line_i,
  output logic             enough_o
);
  localparam int BUF_DW = LINE_DW * DEPTH;
  localparam int SW     = PTR_W + VL_W + 2;

  logic [SW-1:0] end_dw, tot_dw, p_dw, avail;

  always_comb begin
    end_dw = (SW'(newest_line_i) + SW'(1)) * SW'(LINE_DW);
    tot_dw = SW'(valid_lines_i) * SW'(LINE_DW);
    p_dw   = SW'(ptr_i);
    avail  = '0;
    if (valid_lines_i != '0 && p_dw != SW'(BUF_DW)) begin
      if (end_dw > p_dw)
        avail = end_dw - p_dw;
      else if (end_dw < p_dw && (tot_dw + end_dw) > p_dw)
        avail = tot_dw + end_dw - p_dw;
    end
  end

  assign enough_o = avail >= SW'(2);
endmodule

// File: rtl/xtr_assemble.sv
module xtr_assemble
  import xtr_pkg::*;
#(
  parameter int BUF_DW = 16,
  parameter int PTR_W  = 5,
  parameter int AW     = 4
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [31:0]      lo_data_i,
  input  logic [31:0]      hi_data_i,
  output logic [AW-1:0]    lo_addr_o,
  output logic [AW-1:0]    hi_addr_o,
  output logic             split_o,
  output logic             long_o,
  output logic [63:0]      insn_o
);
  logic [PTR_W:0] ptr_plus2;

  assign ptr_plus2 = {1'b0, ptr_i} + (PTR_W+1)'(2);
  // second dword would fall past the physical end
  assign split_o   = ptr_plus2 > (PTR_W+1)'(BUF_DW) &&
                     ptr_i != PTR_W'(BUF_DW);
  assign lo_addr_o = AW'(ptr_i);
  assign hi_addr_o = split_o ? '0 : AW'(ptr_i + PTR_W'(1));
  assign long_o    = is_long(lo_data_i);
  assign insn_o    = long_o ? {hi_data_i, lo_data_i} : {32'h0, lo_data_i};
endmodule

// File: rtl/xtr_ptr.sv
module xtr_ptr #(
  parameter int BUF_DW = 16,
  parameter int PTR_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_ptr_i,
  input  logic             adv_i,
  input  logic             split_i,
  input  logic             long_i,
  input  logic             fill_done_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i)
      ptr_d = load_ptr_i;
    else if (adv_i) begin
      if (split_i)
        ptr_d = long_i ? PTR_W'(1) : PTR_W'(0);
      else
        ptr_d = ptr_q + (long_i ? PTR_W'(2) : PTR_W'(1));
    end else if (fill_done_i && ptr_q == PTR_W'(BUF_DW))
      ptr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/insn_extractor.sv
module insn_extractor #(
  parameter  int LINE_DW = 4,
  parameter  int DEPTH   = 4,
  parameter  int IQ_MAX  = 4,
  localparam int BUF_DW  = LINE_DW * DEPTH,
  localparam int PTR_W   = $clog2(BUF_DW + 1),
  localparam int AW      = $clog2(BUF_DW),
  localparam int VL_W    = $clog2(DEPTH + 1),
  localparam int LN_W    = $clog2(DEPTH),
  localparam int QC_W    = $clog2(IQ_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_ptr_i,
  input  logic             fill_done_i,
  input  logic [VL_W-1:0]  valid_lines_i,
  input  logic [LN_W-1:0]  newest_line_i,
  output logic [AW-1:0]    rd_lo_addr_o,
  input  logic [31:0]      rd_lo_data_i,
  output logic [AW-1:0]    rd_hi_addr_o,
  input  logic [31:0]      rd_hi_data_i,
  input  logic [QC_W-1:0]  q_count_i,
  output logic             push_valid_o,
  output logic [63:0]      push_insn_o,
  output logic             push_long_o,
  output logic [PTR_W-1:0] rd_ptr_o
);
  logic enough, split, long_w, q_room;
  logic [PTR_W-1:0] ptr;

  xtr_avail #(
    .LINE_DW(LINE_DW), .DEPTH(DEPTH), .PTR_W(PTR_W), .VL_W(VL_W), .LN_W(LN_W)
  ) u_avail (
    .ptr_i(ptr), .valid_lines_i(valid_lines_i), .newest_line_i(newest_line_i),
    .enough_o(enough)
  );

  xtr_assemble #(.BUF_DW(BUF_DW), .PTR_W(PTR_W), .AW(AW)) u_asm (
    .ptr_i(ptr), .lo_data_i(rd_lo_data_i), .hi_data_i(rd_hi_data_i),
    .lo_addr_o(rd_lo_addr_o), .hi_addr_o(rd_hi_addr_o),
    .split_o(split), .long_o(long_w), .insn_o(push_insn_o)
  );

  assign q_room       = q_count_i < QC_W'(IQ_MAX);
  assign push_valid_o = enough && q_room;
  assign push_long_o  = long_w;

  xtr_ptr #(.BUF_DW(BUF_DW), .PTR_W(PTR_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_ptr_i(load_ptr_i),
    .adv_i(push_valid_o), .split_i(split), .long_i(long_w),
    .fill_done_i(fill_done_i), .ptr_o(ptr)
  );

  assign rd_ptr_o = ptr;
endmodule

// File: rtl/xtr_checker.sv
module xtr_checker #(
  parameter int BUF_DW = 16,
  parameter int IQ_MAX = 4,
  parameter int PTR_W  = 5,
  parameter int AW     = 4,
  parameter int VL_W   = 3,
  parameter int QC_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [PTR_W-1:0] load_ptr_i,
  input logic             fill_done_i,
  input logic [VL_W-1:0]  valid_lines_i,
  input logic [AW-1:0]    rd_hi_addr_o,
  input logic [QC_W-1:0]  q_count_i,
  input logic             push_valid_o,
  input logic [63:0]      push_insn_o,
  input logic             push_long_o,
  input logic [PTR_W-1:0] rd_ptr_o
);
  a_r4_queue_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_o |-> q_count_i < QC_W'(IQ_MAX));

  a_r3_idle_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ptr_o == PTR_W'(BUF_DW) || valid_lines_i == '0) |-> !push_valid_o);

  a_r5_short_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_o && !push_long_o) |-> push_insn_o[63:32] == 32'h0);

  a_r7_split_hi_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_o && rd_ptr_o == PTR_W'(BUF_DW-1)) |-> rd_hi_addr_o == '0);

  a_r7_split_land: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_o && !load_i && rd_ptr_o == PTR_W'(BUF_DW-1)) |=>
      rd_ptr_o == ($past(push_long_o) ? PTR_W'(1) : PTR_W'(0)));

  a_r6_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_o && !load_i && rd_ptr_o != PTR_W'(BUF_DW-1)) |=>
      rd_ptr_o == $past(rd_ptr_o) + ($past(push_long_o) ? PTR_W'(2) : PTR_W'(1)));

  a_r8_fill_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_done_i && !load_i && rd_ptr_o == PTR_W'(BUF_DW)) |=> rd_ptr_o == '0);

  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rd_ptr_o == $past(load_ptr_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !push_valid_o && !(fill_done_i && rd_ptr_o == PTR_W'(BUF_DW)))
      |=> $stable(rd_ptr_o));
endmodule

bind insn_extractor xtr_checker #(
  .BUF_DW(BUF_DW), .IQ_MAX(IQ_MAX), .PTR_W(PTR_W), .AW(AW), .VL_W(VL_W), .QC_W(QC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_ptr_i(load_ptr_i),
  .fill_done_i(fill_done_i), .valid_lines_i(valid_lines_i),
  .rd_hi_addr_o(rd_hi_addr_o), .q_count_i(q_count_i),
  .push_valid_o(push_valid_o), .push_insn_o(push_insn_o),
  .push_long_o(push_long_o), .rd_ptr_o(rd_ptr_o)
);

// File: tb/insn_extractor_test.sv
`timescale 1ns/1ps
module insn_extractor_test;
  localparam int LDW = 4, DEP = 4, IQ = 4, BDW = LDW * DEP;

  logic clk = 0, rst_ni = 0;
  logic ld = 0, fd = 0;
  logic [4:0] lp = '0;
  logic [2:0] vl = '0;
  logic [1:0] nl = '0;
  logic [2:0] q = '0;
  logic [3:0] lo_addr, hi_addr;
  logic [31:0] lo_data, hi_data;
  logic push_valid, push_long;
  logic [63:0] push_insn;
  logic [4:0] rd_ptr;
  logic [31:0] mem [BDW];

  int total = 0, bad = 0, ptr_m = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign lo_data = mem[lo_addr];
  assign hi_data = mem[hi_addr];

  insn_extractor #(.LINE_DW(LDW), .DEPTH(DEP), .IQ_MAX(IQ)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(ld), .load_ptr_i(lp),
    .fill_done_i(fd), .valid_lines_i(vl), .newest_line_i(nl),
    .rd_lo_addr_o(lo_addr), .rd_lo_data_i(lo_data),
    .rd_hi_addr_o(hi_addr), .rd_hi_data_i(hi_data),
    .q_count_i(q), .push_valid_o(push_valid), .push_insn_o(push_insn),
    .push_long_o(push_long), .rd_ptr_o(rd_ptr)
  );

  function automatic logic [31:0] mk(bit lng, int k);
    return {lng ? 2'b11 : 2'(k & 1), 30'(k * 7919 + 13)};
  endfunction

  function automatic int avail_dw(int p, int v, int n);
    int e = (n + 1) * LDW;
    if (v == 0 || p == BDW) return 0;
    if (e > p) return e - p;
    if (e < p && v * LDW + e > p) return v * LDW + e - p;
    return 0;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit l, int lptr, bit f, bit pop, string tag);
    bit ok, split, lng;
    logic [31:0] lo, hi;
    logic [63:0] ins;
    int nxt;
    @(negedge clk);
    ld = l; lp = 5'(lptr); fd = f;
    #1;
    ok    = avail_dw(ptr_m, vl, nl) >= 2 && q < IQ;
    split = ptr_m == BDW - 1;
    lo    = mem[ptr_m % BDW];
    hi    = split ? mem[0] : mem[(ptr_m + 1) % BDW];
    lng   = lo[31:30] == 2'b11;
    ins   = lng ? {hi, lo} : {32'h0, lo};
    chk(tag, "rd_ptr", rd_ptr, ptr_m);
    chk(ok ? tag : "R4", "push_valid", push_valid, ok);
    if (ok) begin
      chk(split ? "R7" : "R5", "push_insn", push_insn, ins);
      chk("R5", "push_long", push_long, lng);
    end
    if (l) nxt = lptr;
    else if (ok) nxt = split ? (lng ? 1 : 0) : ptr_m + (lng ? 2 : 1);
    else if (f && ptr_m == BDW) nxt = 0;
    else nxt = ptr_m;
    @(posedge clk);
    #1;
    ptr_m = nxt;
    q = 3'(int'(q) + (ok ? 1 : 0) - ((pop && (q > 0 || ok)) ? 1 : 0));
    ld = 0; fd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BDW; i++) mem[i] = mk(0, i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;
    #1;
    chk("R1", "rd_ptr", rd_ptr, 0);
    chk("R1", "push_valid", push_valid, 0);

    // R3: nothing valid
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R3");

    // linear run, queue fills then drains
    mem[0] = mk(0, 0); mem[1] = mk(1, 1); mem[3] = mk(0, 3);
    mem[4] = mk(1, 4); mem[6] = mk(1, 6);
    vl = 2; nl = 1;
    step(1, 0, 0, 0, "R9");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, "R6");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, "R4");

    // R2: a single dword left is not enough
    vl = 1; nl = 0;
    step(1, 3, 0, 1, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R2");

    // run to the physical end, stall, then wrap on fill
    vl = 4; nl = 3;
    mem[12] = mk(0, 12); mem[13] = mk(0, 13); mem[14] = mk(1, 14);
    step(1, 12, 0, 1, "R9");
    step(0, 0, 1, 1, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, "R3");
    step(0, 0, 1, 1, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R6");

    // long split at the last dword
    vl = 4; nl = 0;
    mem[15] = mk(1, 15); mem[0] = mk(0, 20); mem[1] = mk(0, 21);
    step(1, 15, 0, 1, "R9");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R7");

    // short split at the last dword
    mem[15] = mk(0, 30);
    step(1, 15, 0, 1, "R9");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R7");

    // load wins over a push in the same cycle
    vl = 4; nl = 3;
    step(1, 2, 0, 1, "R9");
    step(1, 9, 0, 1, "R9");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule